// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit carries out one of eight bit-movement operations on a byte, word or long operand. It moves the operand by a single bit position on each clock. A start strobe captures all of the following in one cycle: the operation, the size, the operand, the count source, and the incoming extend and carry bits. This capture is the preparation step. After it, the unit runs one step per clock and takes one off the remaining count each time. When the count is used up, it publishes the final value and the N, Z, V, C and X condition bits together with a one-cycle completion pulse.

There are two ways to supply the count. In register form the count comes from a small immediate field or from the low bits of a data register. In memory form the size is forced to word and the count to exactly one, whatever the size and count inputs hold. The published result and flags stay unchanged until the next completion, so a consumer writes the destination only when the completion pulse is high.

Top module: `shrot_unit`

## Requirements
- R1: `op_sel` selects the operation. Bit 2 selects right (1) or left (0). Bits 1:0 select the kind: 00 arithmetic, 01 logical, 10 rotate through extend, 11 plain rotate. Each step moves the operand one bit in that direction. Left shifts bring in 0. An arithmetic right shift copies the sign bit. A logical right shift brings in 0. A plain rotate brings in the bit that left the other end.
- R2: `size_sel` selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits. Result bits above the selected width read 0. N is the top bit of the result at that width, and Z is set when the result is zero at that width.
- R3: When `cnt_from_reg` is 0, the count is `imm_cnt`, and an `imm_cnt` of 0 means 8. When `cnt_from_reg` is 1, the count is `reg_cnt` modulo 64.
- R4: When `mem_mode` is 1, the unit works on a 16-bit operand with a count of exactly one, whatever `size_sel`, `cnt_from_reg`, `imm_cnt` and `reg_cnt` hold.
- R5: A start accepted at a clock edge raises `busy` at that edge. For a count of n, `busy` falls and `done` pulses high for one cycle at the edge n+1 cycles after the start edge.
- R6: `result` and the flags change only at the edge that raises `done`. A `start` while `busy` is high is ignored.
- R7: C is the last bit moved out. X follows C for the arithmetic, logical and rotate-through-extend kinds. For plain rotates, X keeps the `x_in` value captured at start.
- R8: With a count of zero, C and X equal the `c_in` and `x_in` values captured at start, V is 0, and the result is the operand at the selected width.
- R9: For the arithmetic left shift, V is set if the top bit at the selected width changed at any step. For every other operation, V is 0.
- R10: A rotate through extend brings the current X into the vacated end and loads the bit moved out into X. X starts from the `x_in` captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op_sel | input | 3 | Operation select (direction and kind) |
| size_sel | input | 2 | Operand width select |
| mem_mode | input | 1 | Memory form: 16-bit operand, count of one |
| cnt_from_reg | input | 1 | Take the count from `reg_cnt` instead of `imm_cnt` |
| imm_cnt | input | 3 | Immediate count field (0 means 8) |
| reg_cnt | input | 32 | Register count value (used modulo 64) |
| operand | input | 32 | Value to be shifted or rotated |
| x_in | input | 1 | Extend bit captured at start |
| c_in | input | 1 | Carry bit captured at start |
| result | output | 32 | Final value, zero above the selected width |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow (arithmetic left shift only) |
| flag_c | output | 1 | Carry |
| flag_x | output | 1 | Extend |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted remaining count in this unit shows first in timing. `busy` falls and `done` pulses in the wrong cycle, and the bench sees that on the first cycle that differs, because it compares the handshake every clock. A wrong working value, wrong extend bit or wrong sticky overflow stays hidden until the completion edge. At that edge it appears in `result` or in one of the five flags, and the bench compares all of them in the `done` cycle and in every idle cycle after it. Rotate-through-extend runs with many steps are included because an extend bit that goes wrong at step k spreads into every later bit of the result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   // op_sel[2] picks the direction, op_sel[1:0] picks the kind
   typedef enum logic [2:0] {
      OP_ASL  = 3'b000,
      OP_LSL  = 3'b001,
      OP_ROXL = 3'b010,
      OP_ROL  = 3'b011,
      OP_ASR  = 3'b100,
      OP_LSR  = 3'b101,
      OP_ROXR = 3'b110,
      OP_ROR  = 3'b111
   } shrot_op_e;

   localparam logic [1:0] KIND_ARITH = 2'b00;
   localparam logic [1:0] KIND_LOGIC = 2'b01;
   localparam logic [1:0] KIND_ROTX  = 2'b10;
   localparam logic [1:0] KIND_ROT   = 2'b11;

   localparam logic [1:0] SIZE_WORD  = 2'd1;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } shrot_state_e;

endpackage

// File: rtl/shrot_mask.sv
module shrot_mask #(
   parameter int BASE_W = 8,
   parameter int NSIZE  = 3,
   localparam int DATA_W = BASE_W << (NSIZE - 1)
) (
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] top_bit,
   output logic [1:0]        idx
);

   logic [DATA_W-1:0] lane_mask [NSIZE];
   logic [DATA_W-1:0] lane_top  [NSIZE];

   for (genvar g = 0; g < NSIZE; g++) begin : g_lane
      localparam int W = BASE_W << g;
      assign lane_mask[g] = DATA_W'({W{1'b1}});
      assign lane_top[g]  = DATA_W'(1) << (W - 1);
   end

   always_comb begin
      if (int'(size) >= NSIZE) idx = 2'(NSIZE - 1);
      else                     idx = size;
      mask    = lane_mask[idx];
      top_bit = lane_top[idx];
   end

endmodule

// File: rtl/shrot_step.sv
module shrot_step
   import shrot_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int NSIZE  = 3,
   localparam int DATA_W = BASE_W << (NSIZE - 1)
) (
   input  logic [2:0]        op,
   input  logic [1:0]        idx,
   input  logic [DATA_W-1:0] cur,
   input  logic              x_cur,
   output logic [DATA_W-1:0] nxt,
   output logic              out_bit,
   output logic              sign_flip
);

   logic [DATA_W-1:0] lane_nxt  [NSIZE];
   logic              lane_out  [NSIZE];
   logic              lane_flip [NSIZE];

   for (genvar g = 0; g < NSIZE; g++) begin : g_lane
      localparam int W = BASE_W << g;
      logic [W-1:0] v;
      logic [W-1:0] nv;
      logic         fill;
      logic         ob;

      always_comb begin
         v = cur[W-1:0];
         if (!op[2]) begin
            unique case (op[1:0])
               KIND_ROTX: fill = x_cur;
               KIND_ROT:  fill = v[W-1];
               default:   fill = 1'b0;
            endcase
            nv = {v[W-2:0], fill};
            ob = v[W-1];
         end else begin
            unique case (op[1:0])
               KIND_ARITH: fill = v[W-1];
               KIND_ROTX:  fill = x_cur;
               KIND_ROT:   fill = v[0];
               default:    fill = 1'b0;
            endcase
            nv = {fill, v[W-1:1]};
            ob = v[0];
         end
      end

      assign lane_nxt[g]  = DATA_W'(nv);
      assign lane_out[g]  = ob;
      assign lane_flip[g] = nv[W-1] ^ v[W-1];
   end

   always_comb begin
      nxt       = lane_nxt[idx];
      out_bit   = lane_out[idx];
      sign_flip = lane_flip[idx];
   end

endmodule

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
   import shrot_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int NSIZE  = 3,
   parameter int IMM_W  = 3,
   parameter int CNT_W  = 6,
   localparam int DATA_W = BASE_W << (NSIZE - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic [1:0]        size_eff,
   input  logic              mem_mode,
   input  logic              cnt_from_reg,
   input  logic [IMM_W-1:0]  imm_cnt,
   input  logic [CNT_W-1:0]  reg_cnt_lo,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] load_mask,
   input  logic              x_in,
   input  logic              c_in,
   input  logic [DATA_W-1:0] step_nxt,
   input  logic              step_out,
   input  logic              step_flip,
   output logic              busy,
   output logic              finish,
   output logic [DATA_W-1:0] work,
   output logic [2:0]        op_q,
   output logic [1:0]        size_q,
   output logic              x_q,
   output logic              c_q,
   output logic              v_q
);

   shrot_state_e     state;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] load_cnt;

   always_comb begin
      if (mem_mode)          load_cnt = CNT_W'(1);
      else if (cnt_from_reg) load_cnt = reg_cnt_lo;
      else if (imm_cnt == '0) load_cnt = CNT_W'(1 << IMM_W);
      else                   load_cnt = CNT_W'(imm_cnt);
   end

   assign busy   = (state == ST_RUN);
   assign finish = busy && (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         remain <= '0;
         work   <= '0;
         op_q   <= '0;
         size_q <= '0;
         x_q    <= 1'b0;
         c_q    <= 1'b0;
         v_q    <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (start) begin
            state  <= ST_RUN;
            remain <= load_cnt;
            work   <= operand & load_mask;
            op_q   <= op_sel;
            size_q <= size_eff;
            x_q    <= x_in;
            c_q    <= c_in;
            v_q    <= 1'b0;
         end
      end else if (remain == '0) begin
         state <= ST_IDLE;
      end else begin
         remain <= remain - CNT_W'(1);
         work   <= step_nxt;
         c_q    <= step_out;
         if (op_q[1:0] != KIND_ROT) x_q <= step_out;
         if (op_q == OP_ASL && step_flip) v_q <= 1'b1;
      end
   end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
   parameter int BASE_W = 8,
   parameter int NSIZE  = 3,
   localparam int DATA_W = BASE_W << (NSIZE - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              finish,
   input  logic [DATA_W-1:0] work,
   input  logic [DATA_W-1:0] run_mask,
   input  logic [DATA_W-1:0] run_top,
   input  logic              x_q,
   input  logic              c_q,
   input  logic              v_q,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c,
   output logic              flag_x,
   output logic              done
);

   logic [DATA_W-1:0] final_val;
   assign final_val = work & run_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_v <= 1'b0;
         flag_c <= 1'b0;
         flag_x <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= finish;
         if (finish) begin
            result <= final_val;
            flag_n <= |(final_val & run_top);
            flag_z <= (final_val == '0);
            flag_v <= v_q;
            flag_c <= c_q;
            flag_x <= x_q;
         end
      end
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int NSIZE  = 3,
   parameter int IMM_W  = 3,
   parameter int CNT_W  = 6,
   localparam int DATA_W = BASE_W << (NSIZE - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic [1:0]        size_sel,
   input  logic              mem_mode,
   input  logic              cnt_from_reg,
   input  logic [IMM_W-1:0]  imm_cnt,
   input  logic [DATA_W-1:0] reg_cnt,
   input  logic [DATA_W-1:0] operand,
   input  logic              x_in,
   input  logic              c_in,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c,
   output logic              flag_x,
   output logic              busy,
   output logic              done
);

   if (BASE_W < 2) begin : g_bad_base
      $error("shrot_unit: BASE_W must be at least 2");
   end
   if (NSIZE < 1 || NSIZE > 3) begin : g_bad_nsize
      $error("shrot_unit: NSIZE must be 1..3");
   end
   if (CNT_W <= IMM_W || CNT_W > DATA_W) begin : g_bad_cnt
      $error("shrot_unit: CNT_W must exceed IMM_W and fit in DATA_W");
   end

   logic [1:0]        size_eff;
   logic [DATA_W-1:0] load_mask, load_top;
   logic [1:0]        load_idx;
   logic [DATA_W-1:0] run_mask, run_top;
   logic [1:0]        run_idx;
   logic [DATA_W-1:0] work, step_nxt;
   logic              step_out, step_flip, finish;
   logic [2:0]        op_q;
   logic [1:0]        size_q;
   logic              x_q, c_q, v_q;

   assign size_eff = mem_mode ? SIZE_WORD : size_sel;

   shrot_mask #(.BASE_W(BASE_W), .NSIZE(NSIZE)) u_mask_load (
      .size    (size_eff),
      .mask    (load_mask),
      .top_bit (load_top),
      .idx     (load_idx)
   );

   shrot_mask #(.BASE_W(BASE_W), .NSIZE(NSIZE)) u_mask_run (
      .size    (size_q),
      .mask    (run_mask),
      .top_bit (run_top),
      .idx     (run_idx)
   );

   shrot_step #(.BASE_W(BASE_W), .NSIZE(NSIZE)) u_step (
      .op        (op_q),
      .idx       (run_idx),
      .cur       (work),
      .x_cur     (x_q),
      .nxt       (step_nxt),
      .out_bit   (step_out),
      .sign_flip (step_flip)
   );

   shrot_ctrl #(.BASE_W(BASE_W), .NSIZE(NSIZE), .IMM_W(IMM_W), .CNT_W(CNT_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .op_sel       (op_sel),
      .size_eff     (size_eff),
      .mem_mode     (mem_mode),
      .cnt_from_reg (cnt_from_reg),
      .imm_cnt      (imm_cnt),
      .reg_cnt_lo   (reg_cnt[CNT_W-1:0]),
      .operand      (operand),
      .load_mask    (load_mask),
      .x_in         (x_in),
      .c_in         (c_in),
      .step_nxt     (step_nxt),
      .step_out     (step_out),
      .step_flip    (step_flip),
      .busy         (busy),
      .finish       (finish),
      .work         (work),
      .op_q         (op_q),
      .size_q       (size_q),
      .x_q          (x_q),
      .c_q          (c_q),
      .v_q          (v_q)
   );

   shrot_flags #(.BASE_W(BASE_W), .NSIZE(NSIZE)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .finish   (finish),
      .work     (work),
      .run_mask (run_mask),
      .run_top  (run_top),
      .x_q      (x_q),
      .c_q      (c_q),
      .v_q      (v_q),
      .result   (result),
      .flag_n   (flag_n),
      .flag_z   (flag_z),
      .flag_v   (flag_v),
      .flag_c   (flag_c),
      .flag_x   (flag_x),
      .done     (done)
   );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
   import shrot_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic              flag_v,
   input logic              flag_z,
   input logic [2:0]        op_q
);

   // R5
   start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R6
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(op_q));

   // R9
   v_only_asl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q != OP_ASL) |-> !flag_v);

   // R2
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_z == (result == '0)));

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .result (result),
   .flag_v (flag_v),
   .flag_z (flag_z),
   .op_q   (op_q)
);

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  size_sel = '0;
   logic        mem_mode = 1'b0;
   logic        cnt_from_reg = 1'b0;
   logic [2:0]  imm_cnt = '0;
   logic [31:0] reg_cnt = '0;
   logic [31:0] operand = '0;
   logic        x_in = 1'b0;
   logic        c_in = 1'b0;
   logic [31:0] result;
   logic        flag_n, flag_z, flag_v, flag_c, flag_x, busy, done;

   always #10 clk = ~clk;

   shrot_unit u_shrot_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .size_sel(size_sel),
      .mem_mode(mem_mode), .cnt_from_reg(cnt_from_reg), .imm_cnt(imm_cnt),
      .reg_cnt(reg_cnt), .operand(operand), .x_in(x_in), .c_in(c_in),
      .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
      .flag_c(flag_c), .flag_x(flag_x), .busy(busy), .done(done)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_tag = "R5";

   // reference state
   bit              m_busy = 0, m_done = 0;
   int              m_left = 0;
   longint unsigned m_res = 0, p_res = 0;
   bit m_n = 0, m_z = 0, m_v = 0, m_c = 0, m_x = 0;
   bit p_n = 0, p_z = 0, p_v = 0, p_c = 0, p_x = 0;

   function automatic void ref_calc(input int o, input int sz, input longint unsigned val,
                                    input int n, input bit xi, input bit ci,
                                    output longint unsigned r, output bit fn, output bit fz,
                                    output bit fv, output bit fc, output bit fx);
      int w = (sz >= 2) ? 32 : (8 << sz);
      longint unsigned m = (64'd1 << w) - 1;
      r = val & m; fc = ci; fx = xi; fv = 0;
      for (int i = 0; i < n; i++) begin
         bit hi = r[w-1];
         bit lo = r[0];
         case (o)
            0: begin r = (r << 1) & m; if (r[w-1] != hi) fv = 1; fc = hi; fx = hi; end
            1: begin r = (r << 1) & m; fc = hi; fx = hi; end
            2: begin r = ((r << 1) | longint'(fx)) & m; fc = hi; fx = hi; end
            3: begin r = ((r << 1) | longint'(hi)) & m; fc = hi; end
            4: begin r = (r >> 1) | (longint'(hi) << (w-1)); fc = lo; fx = lo; end
            5: begin r = r >> 1; fc = lo; fx = lo; end
            6: begin r = (r >> 1) | (longint'(fx) << (w-1)); fc = lo; fx = lo; end
            default: begin r = (r >> 1) | (longint'(lo) << (w-1)); fc = lo; end
         endcase
      end
      fn = r[w-1];
      fz = (r == 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_left = 0;
         m_res = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_x = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_busy = 0; m_done = 1;
               m_res = p_res; m_n = p_n; m_z = p_z; m_v = p_v; m_c = p_c; m_x = p_x;
            end
         end else if (start) begin
            int n;
            int sz;
            if (mem_mode) begin n = 1; sz = 1; end
            else begin
               sz = size_sel;
               if (cnt_from_reg) n = reg_cnt % 64;
               else n = (imm_cnt == 0) ? 8 : imm_cnt;
            end
            ref_calc(op_sel, sz, operand, n, x_in, c_in, p_res, p_n, p_z, p_v, p_c, p_x);
            m_busy = 1;
            m_left = n + 1;
         end
      end
   end

   always @(negedge clk) begin
      n_cmp++;
      if (busy !== m_busy || done !== m_done) begin
         n_bad++;
         $display("FAIL R5 handshake: busy=%0b done=%0b expected busy=%0b done=%0b",
                  busy, done, m_busy, m_done);
      end else if (result !== m_res[31:0] || flag_n !== m_n || flag_z !== m_z ||
                   flag_v !== m_v || flag_c !== m_c || flag_x !== m_x) begin
         n_bad++;
         $display("FAIL %s data: res=%h nzvcx=%b%b%b%b%b expected res=%h nzvcx=%b%b%b%b%b",
                  cur_tag, result, flag_n, flag_z, flag_v, flag_c, flag_x,
                  m_res[31:0], m_n, m_z, m_v, m_c, m_x);
      end
   end

   task automatic launch(input logic [2:0] o, input logic [1:0] s, input logic [31:0] val,
                         input logic fromreg, input logic [2:0] imm, input logic [31:0] rc,
                         input logic mem, input logic xi, input logic ci, input string tag);
      cur_tag = tag;
      op_sel = o; size_sel = s; operand = val; cnt_from_reg = fromreg; imm_cnt = imm;
      reg_cnt = rc; mem_mode = mem; x_in = xi; c_in = ci; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all eight operations, word size, count 3
      for (int o = 0; o < 8; o++) launch(3'(o), 2'd1, 32'h0000_C3A5, 0, 3'd3, 0, 0, 1, 0, "R1");
      // R2: each size, including the code that maps to long
      for (int s = 0; s < 4; s++) launch(3'd1, 2'(s), 32'hF0F0_8181, 0, 3'd1, 0, 0, 0, 0, "R2");
      launch(3'd5, 2'd0, 32'h1234_5601, 0, 3'd1, 0, 0, 0, 0, "R2");
      // R3: immediate 0 means 8, register modulo 64
      launch(3'd7, 2'd2, 32'h8000_0001, 0, 3'd0, 0, 0, 0, 0, "R3");
      launch(3'd3, 2'd2, 32'h8000_0001, 1, 3'd2, 32'd70, 0, 0, 0, "R3");
      launch(3'd3, 2'd2, 32'h8000_0001, 1, 3'd2, 32'd64, 0, 0, 0, "R3");
      // R4: memory form ignores size and count
      launch(3'd4, 2'd0, 32'hABCD_8003, 0, 3'd5, 0, 1, 0, 0, "R4");
      launch(3'd0, 2'd2, 32'hFFFF_4000, 1, 3'd5, 32'd9, 1, 0, 0, "R4");
      // R6: a start during a long operation is ignored
      cur_tag = "R6";
      op_sel = 3'd6; size_sel = 2'd2; operand = 32'h1357_9BDF; cnt_from_reg = 1;
      reg_cnt = 32'd63; mem_mode = 0; x_in = 1; c_in = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      operand = 32'hFFFF_FFFF; op_sel = 3'd0; reg_cnt = 32'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      // R7: carry and extend source per kind
      launch(3'd5, 2'd0, 32'h0000_0003, 0, 3'd1, 0, 0, 0, 0, "R7");
      launch(3'd3, 2'd0, 32'h0000_0080, 0, 3'd1, 0, 0, 0, 0, "R7");
      launch(3'd7, 2'd1, 32'h0000_0001, 0, 3'd1, 0, 0, 1, 0, "R7");
      // R8: zero count keeps carry and extend
      launch(3'd0, 2'd0, 32'h0000_01FF, 1, 3'd1, 32'd0, 0, 1, 1, "R8");
      launch(3'd6, 2'd1, 32'h0000_0000, 1, 3'd1, 32'd128, 0, 0, 1, "R8");
      // R9: arithmetic left overflow and others clear
      launch(3'd0, 2'd0, 32'h0000_0040, 0, 3'd1, 0, 0, 0, 0, "R9");
      launch(3'd0, 2'd0, 32'h0000_0020, 0, 3'd2, 0, 0, 0, 0, "R9");
      launch(3'd0, 2'd0, 32'h0000_00C0, 0, 3'd1, 0, 0, 0, 0, "R9");
      launch(3'd4, 2'd0, 32'h0000_0040, 0, 3'd7, 0, 0, 0, 0, "R9");
      // R10: rotate through extend
      launch(3'd2, 2'd0, 32'h0000_0081, 0, 3'd0, 0, 0, 1, 0, "R10");
      launch(3'd6, 2'd2, 32'h0000_0001, 1, 3'd0, 32'd33, 0, 0, 0, "R10");
      // mixed patterns
      for (int i = 0; i < 80; i++)
         launch(3'($urandom), 2'($urandom), $urandom, 1'($urandom), 3'($urandom),
                32'($urandom % 80), 1'(($urandom % 8) == 0), 1'($urandom), 1'($urandom), "R1");
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule